// File: doc/BRIEF.md
# Debug Exception Entry Controller

This block decides what a processor core does when a debug event fires while the core is halted for an external debugger. It picks one event from a request vector and works out the return address for the debug link register. It also produces the saved status word, the new CPSR and the handler vector. All of these are presented as registered values with a one-cycle entry pulse, so the register file and fetch unit can commit them.

After an entry the block holds a sticky special debug state flag. While the flag is set, the block does the following:
- It masks IRQ and FIQ and ignores prefetch aborts.
- It turns data aborts into a sticky flag instead of an exception.
- It forces the instruction MMU off and bypasses process-ID remapping for fetches.
- It unlocks software writes to the debug control and breakpoint registers.

The flag ignores mode changes and clears only when the core restores the CPSR from the saved copy.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: When `halt_mode` is 1, the flag is clear and any `evt_req` bit is 1, then one cycle later `entry_pulse` is 1 for exactly one cycle, `sds_active` becomes 1 and `trace_enable` becomes 0.
- R2: Simultaneous requests resolve by lowest bit index: bit0 instruction breakpoint, bit1 data breakpoint, bit2 external break, bit3 trace full, bit4 software breakpoint, bit5 vector trap. `moe` records the winner as 001 instruction, 010 data, 011 software, 100 external, 101 vector trap, 110 trace full, and reads 000 after reset.
- R3: For a data breakpoint, external break or trace-full entry, `lr_dbg` = `pc_next` + 4.
- R4: For an instruction breakpoint, software breakpoint or vector trap entry, `lr_dbg` = `pc_abort` + 4.
- R5: On entry, `spsr_dbg` = `cpsr_in`. `cpsr_dbg` equals `cpsr_in` with bits [7:0] replaced by 8'hD5, which is mode 10101, bit5=0, bit6=1 and bit7=1.
- R6: On entry, `pc_vec` is 0x00000000 when `vec_reloc` is 0 and 0xFFFF0000 when it is 1.
- R7: `irq_take`, `fiq_take` and `pabort_take` are 0 one cycle after any cycle with the flag set. With the flag clear, `irq_take` follows `irq_req` gated by `cpsr_in`[7], `fiq_take` follows `fiq_req` gated by `cpsr_in`[6], and `pabort_take` follows `pabort_req`, each one cycle later.
- R8: A data abort while the flag is set sets `sticky_abort`, which stays until reset, and leaves `dabort_take` at 0. `fault_update` follows `dabort_req` one cycle later in all states.
- R9: `dbg_wr_en` follows `dbg_wr_req` one cycle later, except that it is 0 when `halt_mode` is 1 and the flag is clear.
- R10: `immu_disable` and `pid_bypass` equal `sds_active`.
- R11: The flag clears, and `trace_enable` returns to 1, only on `cpsr_restore`. Events are ignored while the flag is set or when `halt_mode` is 0.
- R12: After reset, all outputs are 0 except `trace_enable`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_mode | input | 1 | Core is in halt debug mode |
| evt_req | input | 6 | Debug event requests, bit index = priority |
| pc_next | input | 32 | PC of the next instruction to execute |
| pc_abort | input | 32 | PC of the aborted instruction |
| cpsr_in | input | 32 | Current CPSR |
| vec_reloc | input | 1 | Vector relocation control bit |
| cpsr_restore | input | 1 | CPSR restored from saved copy |
| irq_req | input | 1 | Interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| pabort_req | input | 1 | Prefetch abort |
| dabort_req | input | 1 | Data abort |
| dbg_wr_req | input | 1 | Software write to debug registers |
| entry_pulse | output | 1 | Entry values valid this cycle |
| lr_dbg | output | 32 | Debug link register value |
| spsr_dbg | output | 32 | Saved status value |
| cpsr_dbg | output | 32 | New CPSR value |
| pc_vec | output | 32 | Handler vector |
| moe | output | 3 | Entry cause code |
| trace_enable | output | 1 | Trace buffer enabled |
| sds_active | output | 1 | Special debug state flag |
| immu_disable | output | 1 | Instruction MMU forced off |
| pid_bypass | output | 1 | Fetch process-ID remap bypassed |
| irq_take | output | 1 | IRQ accepted |
| fiq_take | output | 1 | FIQ accepted |
| pabort_take | output | 1 | Prefetch abort accepted |
| dabort_take | output | 1 | Data abort exception raised |
| fault_update | output | 1 | Fault status/address update strobe |
| sticky_abort | output | 1 | Sticky abort flag |
| dbg_wr_en | output | 1 | Debug register write permitted |

## Verification
The hardest case to reach from the ports is a cycle where the state flag, a CPSR restore, new events and aborts all meet at once. Examples are an event arriving in the same cycle a restore clears the flag, or a data abort landing just as the flag rises. Directed steps first walk each event class through entry and restore, with both vector settings. A long random phase then drives dense, overlapping events, restores and aborts against a behavioural model. This lets those coincidences occur many times.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  localparam int NUM_EVT = 6;
  localparam int EV_IBRK  = 0;
  localparam int EV_DBRK  = 1;
  localparam int EV_EXT   = 2;
  localparam int EV_TBF   = 3;
  localparam int EV_SWBRK = 4;
  localparam int EV_VTRAP = 5;

  typedef enum logic [2:0] {
    MOE_RESET = 3'd0,
    MOE_IBRK  = 3'd1,
    MOE_DBRK  = 3'd2,
    MOE_SWBRK = 3'd3,
    MOE_EXT   = 3'd4,
    MOE_VTRAP = 3'd5,
    MOE_TBF   = 3'd6
  } moe_e;

  localparam logic [4:0] MODE_DEBUG = 5'b10101;

  function automatic moe_e moe_of(input int idx);
    case (idx)
      EV_IBRK:  return MOE_IBRK;
      EV_DBRK:  return MOE_DBRK;
      EV_EXT:   return MOE_EXT;
      EV_TBF:   return MOE_TBF;
      EV_SWBRK: return MOE_SWBRK;
      default:  return MOE_VTRAP;
    endcase
  endfunction

  function automatic logic uses_next_pc(input int idx);
    return (idx == EV_DBRK) || (idx == EV_EXT) || (idx == EV_TBF);
  endfunction
endpackage

// File: rtl/dbg_event_arb.sv
module dbg_event_arb #(
  parameter int NUM = 6,
  localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic [NUM-1:0] req,
  output logic           any,
  output logic [IW-1:0]  sel
);
  always_comb begin
    any = |req;
    sel = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (req[i]) sel = IW'(i);
    end
  end
endmodule

// File: rtl/dbg_frame_gen.sv
module dbg_frame_gen
  import dbg_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NUM  = 6,
  localparam int IW  = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [IW-1:0]   sel,
  input  logic [XLEN-1:0] pc_next,
  input  logic [XLEN-1:0] pc_abort,
  input  logic [XLEN-1:0] cpsr_in,
  input  logic            vec_reloc,
  output logic            entry_pulse,
  output logic [XLEN-1:0] lr_dbg,
  output logic [XLEN-1:0] spsr_dbg,
  output logic [XLEN-1:0] cpsr_dbg,
  output logic [XLEN-1:0] pc_vec,
  output logic [2:0]      moe
);
  localparam logic [XLEN-1:0] VEC_HI  = {{(XLEN-16){1'b1}}, 16'h0000};
  localparam logic [XLEN-1:0] LR_OFFS = XLEN'(4);

  logic [XLEN-1:0] base_pc;
  always_comb base_pc = uses_next_pc(int'(sel)) ? pc_next : pc_abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_pulse <= 1'b0;
      lr_dbg      <= '0;
      spsr_dbg    <= '0;
      cpsr_dbg    <= '0;
      pc_vec      <= '0;
      moe         <= MOE_RESET;
    end else begin
      entry_pulse <= accept;
      if (accept) begin
        lr_dbg   <= base_pc + LR_OFFS;
        spsr_dbg <= cpsr_in;
        cpsr_dbg <= {cpsr_in[XLEN-1:8], 1'b1, 1'b1, 1'b0, MODE_DEBUG};
        pc_vec   <= vec_reloc ? VEC_HI : '0;
        moe      <= moe_of(int'(sel));
      end
    end
  end
endmodule

// File: rtl/dbg_sds_ctl.sv
module dbg_sds_ctl (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic halt_mode,
  input  logic cpsr_restore,
  input  logic irq_mask,
  input  logic fiq_mask,
  input  logic irq_req,
  input  logic fiq_req,
  input  logic pabort_req,
  input  logic dabort_req,
  input  logic dbg_wr_req,
  output logic sds_q,
  output logic trace_enable,
  output logic sticky_abort,
  output logic irq_take,
  output logic fiq_take,
  output logic pabort_take,
  output logic dabort_take,
  output logic fault_update,
  output logic dbg_wr_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sds_q        <= 1'b0;
      trace_enable <= 1'b1;
      sticky_abort <= 1'b0;
      irq_take     <= 1'b0;
      fiq_take     <= 1'b0;
      pabort_take  <= 1'b0;
      dabort_take  <= 1'b0;
      fault_update <= 1'b0;
      dbg_wr_en    <= 1'b0;
    end else begin
      if (accept) begin
        sds_q        <= 1'b1;
        trace_enable <= 1'b0;
      end else if (sds_q && cpsr_restore) begin
        sds_q        <= 1'b0;
        trace_enable <= 1'b1;
      end
      if (sds_q && dabort_req) sticky_abort <= 1'b1;
      irq_take     <= irq_req && !irq_mask && !sds_q;
      fiq_take     <= fiq_req && !fiq_mask && !sds_q;
      pabort_take  <= pabort_req && !sds_q;
      dabort_take  <= dabort_req && !sds_q;
      fault_update <= dabort_req;
      dbg_wr_en    <= dbg_wr_req && (!halt_mode || sds_q);
    end
  end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt_mode,
  input  logic [NUM_EVT-1:0] evt_req,
  input  logic [XLEN-1:0]    pc_next,
  input  logic [XLEN-1:0]    pc_abort,
  input  logic [XLEN-1:0]    cpsr_in,
  input  logic               vec_reloc,
  input  logic               cpsr_restore,
  input  logic               irq_req,
  input  logic               fiq_req,
  input  logic               pabort_req,
  input  logic               dabort_req,
  input  logic               dbg_wr_req,
  output logic               entry_pulse,
  output logic [XLEN-1:0]    lr_dbg,
  output logic [XLEN-1:0]    spsr_dbg,
  output logic [XLEN-1:0]    cpsr_dbg,
  output logic [XLEN-1:0]    pc_vec,
  output logic [2:0]         moe,
  output logic               trace_enable,
  output logic               sds_active,
  output logic               immu_disable,
  output logic               pid_bypass,
  output logic               irq_take,
  output logic               fiq_take,
  output logic               pabort_take,
  output logic               dabort_take,
  output logic               fault_update,
  output logic               sticky_abort,
  output logic               dbg_wr_en
);
  localparam int IW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic          evt_any;
  logic [IW-1:0] evt_sel;
  logic          sds_q;
  logic          accept;

  dbg_event_arb #(.NUM(NUM_EVT)) u_arb (
    .req (evt_req),
    .any (evt_any),
    .sel (evt_sel)
  );

  assign accept = evt_any && halt_mode && !sds_q;

  dbg_frame_gen #(.XLEN(XLEN), .NUM(NUM_EVT)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .sel         (evt_sel),
    .pc_next     (pc_next),
    .pc_abort    (pc_abort),
    .cpsr_in     (cpsr_in),
    .vec_reloc   (vec_reloc),
    .entry_pulse (entry_pulse),
    .lr_dbg      (lr_dbg),
    .spsr_dbg    (spsr_dbg),
    .cpsr_dbg    (cpsr_dbg),
    .pc_vec      (pc_vec),
    .moe         (moe)
  );

  dbg_sds_ctl u_sds (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .halt_mode    (halt_mode),
    .cpsr_restore (cpsr_restore),
    .irq_mask     (cpsr_in[7]),
    .fiq_mask     (cpsr_in[6]),
    .irq_req      (irq_req),
    .fiq_req      (fiq_req),
    .pabort_req   (pabort_req),
    .dabort_req   (dabort_req),
    .dbg_wr_req   (dbg_wr_req),
    .sds_q        (sds_q),
    .trace_enable (trace_enable),
    .sticky_abort (sticky_abort),
    .irq_take     (irq_take),
    .fiq_take     (fiq_take),
    .pabort_take  (pabort_take),
    .dabort_take  (dabort_take),
    .fault_update (fault_update),
    .dbg_wr_en    (dbg_wr_en)
  );

  assign sds_active   = sds_q;
  assign immu_disable = sds_q;
  assign pid_bypass   = sds_q;
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            accept,
  input logic            entry_pulse,
  input logic            sds_active,
  input logic            trace_enable,
  input logic            cpsr_restore,
  input logic            dabort_req,
  input logic            irq_take,
  input logic            fiq_take,
  input logic            pabort_take,
  input logic            dabort_take,
  input logic            sticky_abort,
  input logic [XLEN-1:0] cpsr_dbg,
  input logic [XLEN-1:0] pc_vec
);
  assert_entry_sets_state_R1: assert property (@(posedge clk) disable iff (rst)
    accept |=> (entry_pulse && sds_active && !trace_enable));

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    entry_pulse |=> !entry_pulse);

  assert_cpsr_low_byte_R5: assert property (@(posedge clk) disable iff (rst)
    entry_pulse |-> (cpsr_dbg[7:0] == 8'hD5));

  assert_vector_value_R6: assert property (@(posedge clk) disable iff (rst)
    entry_pulse |-> (pc_vec == '0 || pc_vec == {{(XLEN-16){1'b1}}, 16'h0000}));

  assert_masks_in_state_R7: assert property (@(posedge clk) disable iff (rst)
    sds_active |=> (!irq_take && !fiq_take && !pabort_take));

  assert_abort_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (sds_active && dabort_req) |=> (sticky_abort && !dabort_take));

  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (rst)
    sticky_abort |=> sticky_abort);

  assert_state_persists_R11: assert property (@(posedge clk) disable iff (rst)
    (sds_active && !cpsr_restore) |=> sds_active);
endmodule

bind dbg_entry_ctrl dbg_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .accept       (accept),
  .entry_pulse  (entry_pulse),
  .sds_active   (sds_active),
  .trace_enable (trace_enable),
  .cpsr_restore (cpsr_restore),
  .dabort_req   (dabort_req),
  .irq_take     (irq_take),
  .fiq_take     (fiq_take),
  .pabort_take  (pabort_take),
  .dabort_take  (dabort_take),
  .sticky_abort (sticky_abort),
  .cpsr_dbg     (cpsr_dbg),
  .pc_vec       (pc_vec)
);

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        halt_mode;
  logic [5:0]  evt_req;
  logic [31:0] pc_next, pc_abort, cpsr_in;
  logic        vec_reloc, cpsr_restore, irq_req, fiq_req, pabort_req, dabort_req, dbg_wr_req;
  logic        entry_pulse;
  logic [31:0] lr_dbg, spsr_dbg, cpsr_dbg, pc_vec;
  logic [2:0]  moe;
  logic        trace_enable, sds_active, immu_disable, pid_bypass;
  logic        irq_take, fiq_take, pabort_take, dabort_take, fault_update, sticky_abort, dbg_wr_en;

  always #10 clk = ~clk;

  dbg_entry_ctrl u_dut (
    .clk(clk), .rst(rst), .halt_mode(halt_mode), .evt_req(evt_req),
    .pc_next(pc_next), .pc_abort(pc_abort), .cpsr_in(cpsr_in), .vec_reloc(vec_reloc),
    .cpsr_restore(cpsr_restore), .irq_req(irq_req), .fiq_req(fiq_req),
    .pabort_req(pabort_req), .dabort_req(dabort_req), .dbg_wr_req(dbg_wr_req),
    .entry_pulse(entry_pulse), .lr_dbg(lr_dbg), .spsr_dbg(spsr_dbg), .cpsr_dbg(cpsr_dbg),
    .pc_vec(pc_vec), .moe(moe), .trace_enable(trace_enable), .sds_active(sds_active),
    .immu_disable(immu_disable), .pid_bypass(pid_bypass), .irq_take(irq_take),
    .fiq_take(fiq_take), .pabort_take(pabort_take), .dabort_take(dabort_take),
    .fault_update(fault_update), .sticky_abort(sticky_abort), .dbg_wr_en(dbg_wr_en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit          m_pulse, m_trace, m_sds, m_sticky;
  bit          m_irq, m_fiq, m_pab, m_dab, m_fupd, m_wr;
  logic [31:0] m_lr, m_spsr, m_cpsr, m_pc;
  int          m_moe;
  int          entries = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int code_of(input int idx);
    case (idx)
      0: return 1;   // instruction breakpoint
      1: return 2;   // data breakpoint
      2: return 4;   // external break
      3: return 6;   // trace full
      4: return 3;   // software breakpoint
      default: return 5; // vector trap
    endcase
  endfunction

  task automatic model_step();
    bit old_sds;
    int win;
    if (rst) begin
      m_pulse = 0; m_trace = 1; m_sds = 0; m_sticky = 0;
      m_irq = 0; m_fiq = 0; m_pab = 0; m_dab = 0; m_fupd = 0; m_wr = 0;
      m_lr = 0; m_spsr = 0; m_cpsr = 0; m_pc = 0; m_moe = 0;
      return;
    end
    old_sds = m_sds;
    win = -1;
    for (int i = 5; i >= 0; i--) if (evt_req[i]) win = i;
    m_pulse = halt_mode && !old_sds && (win >= 0);
    if (m_pulse) begin
      entries++;
      m_moe  = code_of(win);
      m_lr   = ((win == 1 || win == 2 || win == 3) ? pc_next : pc_abort) + 32'd4;
      m_spsr = cpsr_in;
      m_cpsr = {cpsr_in[31:8], 8'hD5};
      m_pc   = vec_reloc ? 32'hFFFF_0000 : 32'h0;
      m_sds = 1; m_trace = 0;
    end else if (old_sds && cpsr_restore) begin
      m_sds = 0; m_trace = 1;
    end
    if (old_sds && dabort_req) m_sticky = 1;
    m_irq  = irq_req && !cpsr_in[7] && !old_sds;
    m_fiq  = fiq_req && !cpsr_in[6] && !old_sds;
    m_pab  = pabort_req && !old_sds;
    m_dab  = dabort_req && !old_sds;
    m_fupd = dabort_req;
    m_wr   = dbg_wr_req && (!halt_mode || old_sds);
  endtask

  task automatic compare();
    check("R1", "entry_pulse", 32'(entry_pulse), 32'(m_pulse));
    check("R2", "moe", 32'(moe), 32'(m_moe));
    check("R3/R4", "lr_dbg", lr_dbg, m_lr);
    check("R5", "spsr_dbg", spsr_dbg, m_spsr);
    check("R5", "cpsr_dbg", cpsr_dbg, m_cpsr);
    check("R6", "pc_vec", pc_vec, m_pc);
    check("R7", "irq_take", 32'(irq_take), 32'(m_irq));
    check("R7", "fiq_take", 32'(fiq_take), 32'(m_fiq));
    check("R7", "pabort_take", 32'(pabort_take), 32'(m_pab));
    check("R8", "dabort_take", 32'(dabort_take), 32'(m_dab));
    check("R8", "fault_update", 32'(fault_update), 32'(m_fupd));
    check("R8", "sticky_abort", 32'(sticky_abort), 32'(m_sticky));
    check("R9", "dbg_wr_en", 32'(dbg_wr_en), 32'(m_wr));
    check("R10", "immu_disable", 32'(immu_disable), 32'(m_sds));
    check("R10", "pid_bypass", 32'(pid_bypass), 32'(m_sds));
    check("R11", "sds_active", 32'(sds_active), 32'(m_sds));
    check("R1/R11", "trace_enable", 32'(trace_enable), 32'(m_trace));
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    evt_req = 0; cpsr_restore = 0; irq_req = 0; fiq_req = 0;
    pabort_req = 0; dabort_req = 0; dbg_wr_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; halt_mode = 0; vec_reloc = 0;
    pc_next = 32'h1000; pc_abort = 32'h0FFC; cpsr_in = 32'h6000_0010;
    idle();
    tick(); tick();
    // R12: reset state at the ports
    check("R12", "reset entry_pulse", 32'(entry_pulse), 0);
    check("R12", "reset moe", 32'(moe), 0);
    check("R12", "reset trace_enable", 32'(trace_enable), 1);
    check("R12", "reset sds_active", 32'(sds_active), 0);
    rst = 0;

    // event outside halt mode: ignored (R11)
    evt_req = 6'b000001; tick(); idle(); tick();
    check("R11", "no entry outside halt", 32'(sds_active), 0);

    // each event class alone, both vector settings
    halt_mode = 1;
    for (int e = 0; e < 6; e++) begin
      vec_reloc = e[0];
      pc_next = 32'h2000 + 32'(e * 16); pc_abort = 32'h3000 + 32'(e * 16);
      cpsr_in = 32'hA000_0013 ^ 32'(e << 8);
      dbg_wr_req = 1; tick();            // locked in halt (R9)
      evt_req = 6'(1 << e); tick();
      idle();
      evt_req = 6'b111111; irq_req = 1; fiq_req = 1; pabort_req = 1;
      dabort_req = 1; dbg_wr_req = 1;    // all ignored / masked in state
      tick();
      idle(); tick();
      cpsr_restore = 1; tick();
      idle(); tick();
    end

    // simultaneous requests (R2)
    evt_req = 6'b111110; tick(); idle(); cpsr_restore = 1; tick(); idle(); tick();
    evt_req = 6'b111000; tick(); idle(); cpsr_restore = 1; tick(); idle(); tick();
    evt_req = 6'b110000; tick(); idle(); cpsr_restore = 1; tick(); idle(); tick();

    // interrupts with CPSR masks outside the state (R7)
    cpsr_in = 32'h0000_0080; irq_req = 1; fiq_req = 1; tick();
    cpsr_in = 32'h0000_0040; tick();
    cpsr_in = 32'h0000_0000; pabort_req = 1; dabort_req = 1; tick();
    idle(); halt_mode = 0; dbg_wr_req = 1; tick(); idle(); tick();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      halt_mode    = ($urandom_range(0, 7) != 0);
      evt_req      = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'd0;
      pc_next      = $urandom; pc_abort = $urandom; cpsr_in = $urandom;
      vec_reloc    = 1'($urandom);
      cpsr_restore = ($urandom_range(0, 5) == 0);
      irq_req      = 1'($urandom); fiq_req = 1'($urandom);
      pabort_req   = 1'($urandom); dabort_req = ($urandom_range(0, 15) == 0);
      dbg_wr_req   = 1'($urandom);
      rst          = ($urandom_range(0, 499) == 0);
      tick();
    end
    rst = 0; idle(); tick();
    check("R1", "entries observed", 32'(entries > 20), 1);
    finish_run();
  end
endmodule